// File: doc/BRIEF.md
# Packed 64-bit SIMD Add and Logic Unit

This block is a single-stage execution unit for packed integer arithmetic on 64-bit operands. An operation is chosen by an 8-bit opcode. The unit treats the two operands as eight byte lanes, four word lanes or two doubleword lanes, and adds them lane by lane. A lane can wrap around on overflow, clamp as a signed value, or clamp as an unsigned value. The unit also computes the 64-bit bitwise AND, and an AND-NOT in which the destination operand is the one that is inverted.

The issuing pipeline presents the opcode, the destination value (operand A), the source value (operand B: a register or a memory qword) and a valid strobe. One clock later the unit returns a registered result with a valid flag. An opcode outside the supported set is reported through an illegal flag. The unit accepts a new operation on every cycle. Instruction fetch, operand addressing and register writeback belong to the surrounding pipeline.

Top module: `pk64_alu`

## Requirements
- R1: Opcode 0xFC adds byte lanes, 0xFD adds 16-bit lanes and 0xFE adds 32-bit lanes, each modulo 2^lane-width. A carry out of one lane never reaches the next lane.
- R2: Opcode 0xEC (byte lanes) and opcode 0xED (16-bit lanes) add as two's-complement values. A positive overflow clamps to 0x7F / 0x7FFF and a negative overflow clamps to 0x80 / 0x8000.
- R3: Opcode 0xDC (byte lanes) and opcode 0xDD (16-bit lanes) add as unsigned values and clamp a carry-out to 0xFF / 0xFFFF.
- R4: Opcode 0xDB returns A AND B over all 64 bits.
- R5: Opcode 0xDF returns (NOT A) AND B, where A is the destination operand.
- R6: The result of an operation accepted with in_valid high appears with out_valid high on the next clock edge. Operations issued on consecutive cycles each produce a result on consecutive cycles.
- R7: An accepted opcode outside the nine listed above gives out_valid and out_illegal high for exactly that one result cycle, with out_result equal to zero.
- R8: While rst is high, the unit clears out_valid, out_illegal and out_result to zero on each clock edge.
- R9: A cycle with in_valid low gives out_valid and out_illegal low on the next cycle, and out_result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_opcode | input | 8 | Operation select byte |
| in_a | input | 64 | Destination operand A |
| in_b | input | 64 | Source operand B |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 64 | Registered result |
| out_illegal | output | 1 | Unsupported opcode flag |

## Verification
The bench checks that a wrapping lane add discards its carry at each lane edge. A design that let the carry through would corrupt the neighbouring lane, for example 0x00FF + 0x0001 would give 0x0100 instead of 0x0000 in byte mode. It checks both saturation edges: a signed design that tested the carry instead of the sign overflow would clamp 0x80 + 0xFF to the wrong bound, and an unsigned design that ignored the carry would wrap 0xFF + 0x01 to zero. It checks that AND-NOT inverts A, since a design that inverted B would produce a visibly different pattern. It also sends unlisted opcodes next to legal ones (0xDE, 0xFF, 0x00) and checks for a zero result with a one-cycle flag, and it runs a long stream issued back to back to catch any lost or duplicated result.

// File: rtl/pk64_pkg.sv
package pk64_pkg;

  localparam logic [7:0] OPC_ADD_B_WRAP = 8'hFC;
  localparam logic [7:0] OPC_ADD_H_WRAP = 8'hFD;
  localparam logic [7:0] OPC_ADD_W_WRAP = 8'hFE;
  localparam logic [7:0] OPC_ADD_B_SSAT = 8'hEC;
  localparam logic [7:0] OPC_ADD_H_SSAT = 8'hED;
  localparam logic [7:0] OPC_ADD_B_USAT = 8'hDC;
  localparam logic [7:0] OPC_ADD_H_USAT = 8'hDD;
  localparam logic [7:0] OPC_LOG_AND    = 8'hDB;
  localparam logic [7:0] OPC_LOG_ANDN   = 8'hDF;

  typedef enum logic [1:0] {
    POL_WRAP = 2'd0,
    POL_SSAT = 2'd1,
    POL_USAT = 2'd2
  } pol_e;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } lwid_e;

  typedef enum logic [1:0] {
    K_ADD  = 2'd0,
    K_AND  = 2'd1,
    K_ANDN = 2'd2,
    K_BAD  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e kind;
    lwid_e lwid;
    pol_e  pol;
  } uop_t;

endpackage

// File: rtl/pk64_decode.sv
module pk64_decode
  import pk64_pkg::*;
(
  input  logic [7:0] opcode,
  output uop_t       uop
);

  always_comb begin
    uop = '{kind: K_BAD, lwid: LW_8, pol: POL_WRAP};
    unique case (opcode)
      OPC_ADD_B_WRAP: uop = '{kind: K_ADD,  lwid: LW_8,  pol: POL_WRAP};
      OPC_ADD_H_WRAP: uop = '{kind: K_ADD,  lwid: LW_16, pol: POL_WRAP};
      OPC_ADD_W_WRAP: uop = '{kind: K_ADD,  lwid: LW_32, pol: POL_WRAP};
      OPC_ADD_B_SSAT: uop = '{kind: K_ADD,  lwid: LW_8,  pol: POL_SSAT};
      OPC_ADD_H_SSAT: uop = '{kind: K_ADD,  lwid: LW_16, pol: POL_SSAT};
      OPC_ADD_B_USAT: uop = '{kind: K_ADD,  lwid: LW_8,  pol: POL_USAT};
      OPC_ADD_H_USAT: uop = '{kind: K_ADD,  lwid: LW_16, pol: POL_USAT};
      OPC_LOG_AND:    uop = '{kind: K_AND,  lwid: LW_8,  pol: POL_WRAP};
      OPC_LOG_ANDN:   uop = '{kind: K_ANDN, lwid: LW_8,  pol: POL_WRAP};
      default:        uop = '{kind: K_BAD,  lwid: LW_8,  pol: POL_WRAP};
    endcase
  end

endmodule

// File: rtl/pk64_lane_add.sv
module pk64_lane_add
  import pk64_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  pol_e          pol,
  output logic [LW-1:0] y
);

  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] UMAX = {LW{1'b1}};

  logic [LW:0] raw;
  logic        carry;
  logic        sovf;

  always_comb begin
    raw   = {1'b0, a} + {1'b0, b};
    carry = raw[LW];
    sovf  = (a[LW-1] == b[LW-1]) && (raw[LW-1] != a[LW-1]);
    unique case (pol)
      POL_SSAT: y = sovf ? (a[LW-1] ? SMIN : SMAX) : raw[LW-1:0];
      POL_USAT: y = carry ? UMAX : raw[LW-1:0];
      default:  y = raw[LW-1:0];
    endcase
  end

endmodule

// File: rtl/pk64_lane_bank.sv
module pk64_lane_bank
  import pk64_pkg::*;
#(
  parameter int DW = 64,
  parameter int LW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  pol_e          pol,
  output logic [DW-1:0] y
);

  localparam int LANES = DW / LW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pk64_lane_add #(.LW(LW)) u_lane (
      .a  (a[i*LW +: LW]),
      .b  (b[i*LW +: LW]),
      .pol(pol),
      .y  (y[i*LW +: LW])
    );
  end

endmodule

// File: rtl/pk64_alu.sv
module pk64_alu
  import pk64_pkg::*;
#(
  parameter int DW     = 64,
  parameter int OPC_W  = 8,
  parameter int MIN_LW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPC_W-1:0] in_opcode,
  input  logic [DW-1:0]    in_a,
  input  logic [DW-1:0]    in_b,
  output logic             out_valid,
  output logic [DW-1:0]    out_result,
  output logic             out_illegal
);

  localparam int NBANK = 3;

  uop_t          uop;
  logic [DW-1:0] bank_y [NBANK];
  logic [DW-1:0] add_y;
  logic [DW-1:0] next_y;
  logic          bad;

  pk64_decode u_dec (
    .opcode(in_opcode[7:0]),
    .uop   (uop)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    pk64_lane_bank #(.DW(DW), .LW(MIN_LW << g)) u_bank (
      .a  (in_a),
      .b  (in_b),
      .pol(uop.pol),
      .y  (bank_y[g])
    );
  end

  always_comb begin
    unique case (uop.lwid)
      LW_16:   add_y = bank_y[1];
      LW_32:   add_y = bank_y[2];
      default: add_y = bank_y[0];
    endcase
  end

  always_comb begin
    bad = (uop.kind == K_BAD);
    unique case (uop.kind)
      K_ADD:   next_y = add_y;
      K_AND:   next_y = in_a & in_b;
      K_ANDN:  next_y = ~in_a & in_b;
      default: next_y = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && bad;
      if (in_valid) out_result <= next_y;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal && $stable(out_result))); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_valid && out_result == '0)); // R7
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    (out_illegal && !in_valid) |=> !out_illegal); // R7
  AST_AND_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == OPC_LOG_AND) |=> ((out_result & ~$past(in_b)) == '0)); // R4
  AST_ANDN_DEST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == OPC_LOG_ANDN) |=> ((out_result & $past(in_a)) == '0)); // R5

endmodule

// File: tb/pk64_alu_tb.sv
`timescale 1ns/1ps
module pk64_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_opcode;
  logic [63:0] in_a, in_b;
  logic        out_valid, out_illegal;
  logic [63:0] out_result;

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;
  logic [63:0] last_res;

  typedef struct {
    logic        ill;
    logic [63:0] res;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  pk64_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic exp_t model(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
    exp_t e;
    int w, m;
    longint mask, half;
    e.ill = 1'b0; e.res = '0; w = 0; m = 0;
    case (op)
      8'hFC: begin w = 8;  m = 0; e.tag = "R1"; end
      8'hFD: begin w = 16; m = 0; e.tag = "R1"; end
      8'hFE: begin w = 32; m = 0; e.tag = "R1"; end
      8'hEC: begin w = 8;  m = 1; e.tag = "R2"; end
      8'hED: begin w = 16; m = 1; e.tag = "R2"; end
      8'hDC: begin w = 8;  m = 2; e.tag = "R3"; end
      8'hDD: begin w = 16; m = 2; e.tag = "R3"; end
      8'hDB: begin e.res = a & b;  e.tag = "R4"; end
      8'hDF: begin e.res = ~a & b; e.tag = "R5"; end
      default: begin e.ill = 1'b1; e.tag = "R7"; end
    endcase
    if (w != 0) begin
      mask = (longint'(1) <<< w) - 1;
      half = longint'(1) <<< (w - 1);
      for (int i = 0; i < 64 / w; i++) begin
        longint ua, ub, s;
        ua = longint'(a >> (i * w)) & mask;
        ub = longint'(b >> (i * w)) & mask;
        if (m == 1) begin
          if (ua >= half) ua = ua - (mask + 1);
          if (ub >= half) ub = ub - (mask + 1);
          s = ua + ub;
          if (s > half - 1) s = half - 1;
          if (s < -half) s = -half;
        end else begin
          s = ua + ub;
          if (m == 2 && s > mask) s = mask;
        end
        s = s & mask;
        e.res = e.res | (64'(s) << (i * w));
      end
    end
    return e;
  endfunction

  task automatic issue(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_a = a; in_b = b;
    sb.push_back(model(op, a, b));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_opcode = $urandom; in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
    end
  endtask

  // monitor: samples at the falling edge, between register updates
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        exp_t e;
        n_chk++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R6: unexpected result %h, expected none", out_result);
        end else begin
          e = sb.pop_front();
          if (out_result !== e.res || out_illegal !== e.ill) begin
            n_fail++;
            $display("FAIL %s: result %h ill %b, expected %h ill %b", e.tag, out_result, out_illegal, e.res, e.ill);
          end
        end
        last_res = out_result;
      end else begin
        n_chk++;
        if (out_illegal !== 1'b0 || out_result !== last_res) begin
          n_fail++;
          $display("FAIL R9: idle ill %b result %h, expected ill 0 result %h", out_illegal, out_result, last_res);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; in_opcode = 8'hFC;
    in_a = 64'hFFFF_FFFF_FFFF_FFFF; in_b = 64'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== 64'h0) begin
      n_fail++;
      $display("FAIL R8: reset outputs v%b i%b %h, expected 0 0 0", out_valid, out_illegal, out_result);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    last_res = '0;
    @(negedge clk);
    mon_on = 1'b1;

    // R1 wrap, carry stays inside lane
    issue(8'hFC, 64'h00FF_0080_7F01_FFFF, 64'h0001_0080_0101_0001);
    issue(8'hFD, 64'h0000_FFFF_8000_1234, 64'h0000_0001_8000_4321);
    issue(8'hFE, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    // R2 signed saturation, both bounds
    issue(8'hEC, 64'h7F80_7F80_1080_7FF0, 64'h01FF_7F80_10FF_0110);
    issue(8'hED, 64'h7FFF_8000_0001_FFFF, 64'h0001_FFFF_0002_FFFF);
    // R3 unsigned saturation
    issue(8'hDC, 64'hFF01_80FE_0000_7F7F, 64'h01FE_8001_0000_8081);
    issue(8'hDD, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_FFFE_8001);
    // R4 / R5
    issue(8'hDB, 64'hF0F0_FFFF_0000_1234, 64'hFF00_5A5A_FFFF_FFFF);
    issue(8'hDF, 64'hF0F0_FFFF_0000_1234, 64'hFF00_5A5A_FFFF_FFFF);
    // R7 illegal codes between legal ones
    issue(8'hDE, 64'h1, 64'h2);
    issue(8'hFC, 64'h0101_0101_0101_0101, 64'h0202_0202_0202_0202);
    issue(8'hFF, 64'hFFFF, 64'hFFFF);
    issue(8'h00, 64'h5, 64'h6);
    // R9 idle with changing inputs
    idle(3);
    // R6 back-to-back stream over all codes
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      case ($urandom % 11)
        0: op = 8'hFC; 1: op = 8'hFD; 2: op = 8'hFE; 3: op = 8'hEC;
        4: op = 8'hED; 5: op = 8'hDC; 6: op = 8'hDD; 7: op = 8'hDB;
        8: op = 8'hDF; 9: op = 8'hE0; default: op = 8'($urandom);
      endcase
      issue(op, {$urandom, $urandom}, {$urandom, $urandom});
      if (n % 37 == 0) idle(1);
    end
    idle(4);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R6: %0d results missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule